// File: doc/BRIEF.md
# Tagged Calibration Shadow-Register Loader

This block keeps five working registers in step with a small bit-addressable nonvolatile store. The registers are one 12-bit configuration word and four 12-bit trim coefficients: offset, offset drift, span and span drift. A reload walks the first five 16-bit words of the store one bit per clock through an external read port. It accepts a word into its register only when the word's upper nibble carries the tag expected for that slot. A word whose tag is wrong leaves its register as it was and raises a per-word error flag.

A reload has three triggers:

- the end of reset;
- a rising edge on the select input, unless the hold flag from the serial front end is set;
- a periodic refresh tick, counted in system clocks, which runs only while write-enable is high and no serial session is unlocked.

A host can also stage new values for any of the five registers. Staged values reach the working registers together on a single load strobe, with no select toggling needed.

Top module: `shadow_loader`

## Requirements
- R1: While reset is asserted, all five working registers and all error flags are zero. On the first clock after reset is released, busy rises and a full reload runs without any other trigger.
- R2: Store bit address 16*w+i is bit i of word w. Word 0 feeds the configuration register, word 1 offset, word 2 offset drift, word 3 span and word 4 span drift. A reload reads addresses 0 to 79 in rising order, one per clock, with busy high for exactly 80 clocks.
- R3: The register for word w (w = 0 to 4) takes bits 11:0 of that word only when bits 15:12 equal 8+w. Otherwise the register keeps its value and tag_err[w] is set. tag_err[w] is cleared by a later reload in which word w passes its tag check.
- R4: A rising edge on sel starts a reload when u_flag is 0. When u_flag is 1, a rising edge on sel starts no reload and the registers keep their values.
- R5: With wr_en high and session_open low, a reload starts every REFRESH_CYCLES clocks. With wr_en low, or with session_open high, no periodic reload occurs.
- R6: host_we with host_idx 0 to 4 writes host_data into a staging register and leaves the working registers unchanged. A later host_load pulse copies every staged value into its working register at once. host_idx values 5 to 7 write nothing.
- R7: A trigger that arrives while a reload is running is held. One further reload starts once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-up |
| sel | input | 1 | Select level; its rising edge requests a reload |
| u_flag | input | 1 | Hold flag; 1 blocks select-edge reloads |
| wr_en | input | 1 | Write-enable level; 1 enables periodic refresh |
| session_open | input | 1 | Serial session unlocked; 1 suppresses refresh |
| host_we | input | 1 | Staging write strobe |
| host_idx | input | 3 | Staging register index (0 to 4 valid) |
| host_data | input | 12 | Staging write data |
| host_load | input | 1 | Copies staged values into working registers |
| mem_addr | output | 7 | Store read bit address |
| mem_bit | input | 1 | Store bit at mem_addr, same cycle |
| cfg_q | output | 12 | Configuration register |
| off_q | output | 12 | Offset coefficient |
| offtc_q | output | 12 | Offset-drift coefficient |
| fso_q | output | 12 | Span coefficient |
| fsotc_q | output | 12 | Span-drift coefficient |
| busy | output | 1 | Reload in progress |
| tag_err | output | 5 | Per-word tag-check failure flags |

## Verification
A wrong bit counter or word index appears at the ports within one reload, about 80 clocks. It shows as a coefficient holding another slot's bits, or as a tag flag raised on the wrong word. A broken trigger gate shows as busy rising when it should not, or staying low when it should rise. The bench detects this within one refresh period or a few clocks after a select edge. Faulty staging logic shows on the cycle after host_load, when either more or fewer registers change than were written.

// File: rtl/shadow_loader.sv
module shadow_loader #(
  parameter int REFRESH_CYCLES = 625000,
  parameter int COEF_W = 12,
  parameter int TAG_W = 4,
  parameter int NREG = 5,
  parameter int ADDR_W = 7
)(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic u_flag,
  input  logic wr_en,
  input  logic session_open,
  input  logic host_we,
  input  logic [$clog2(NREG)-1:0] host_idx,
  input  logic [COEF_W-1:0] host_data,
  input  logic host_load,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic mem_bit,
  output logic [COEF_W-1:0] cfg_q,
  output logic [COEF_W-1:0] off_q,
  output logic [COEF_W-1:0] offtc_q,
  output logic [COEF_W-1:0] fso_q,
  output logic [COEF_W-1:0] fsotc_q,
  output logic busy,
  output logic [NREG-1:0] tag_err
);
  localparam int WORD_W = COEF_W + TAG_W;
  localparam int LOAD_BITS = NREG * WORD_W;
  localparam int CNT_W = $clog2(LOAD_BITS);
  localparam int POS_W = $clog2(WORD_W);
  localparam int WIDX_W = CNT_W - POS_W;
  localparam int IDX_W = $clog2(NREG);
  localparam int REF_W = $clog2(REFRESH_CYCLES);
  localparam int TAG_BASE = 8;

  logic sel_d, pend;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-2:0] sh;
  logic [REF_W-1:0] rcnt;
  logic [COEF_W-1:0] wreg [NREG];
  logic [COEF_W-1:0] stage [NREG];
  logic [NREG-1:0] dirty;

  wire sel_rise = sel & ~sel_d;
  wire refresh_on = wr_en & ~session_open;
  wire tick = refresh_on && (rcnt == REF_W'(REFRESH_CYCLES - 1));
  wire req = (sel_rise & ~u_flag) | tick;
  wire [POS_W-1:0] pos = cnt[POS_W-1:0];
  wire [WIDX_W-1:0] widx = cnt[CNT_W-1:POS_W];
  wire word_end = busy && (pos == POS_W'(WORD_W - 1));
  wire [WORD_W-1:0] word = {mem_bit, sh};
  wire [TAG_W-1:0] tag_exp = TAG_W'(TAG_BASE) + TAG_W'(widx);
  wire tag_ok = word[WORD_W-1 -: TAG_W] == tag_exp;

  assign mem_addr = ADDR_W'(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      pend  <= 1'b1;
      sel_d <= 1'b1;
      rcnt  <= '0;
      sh    <= '0;
    end else begin
      sel_d <= sel;
      rcnt  <= (!refresh_on || tick) ? '0 : rcnt + 1'b1;
      if (busy) begin
        if (pos != POS_W'(WORD_W - 1)) sh[pos] <= mem_bit;
        if (req) pend <= 1'b1;
        if (cnt == CNT_W'(LOAD_BITS - 1)) begin
          busy <= 1'b0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (req || pend) begin
        busy <= 1'b1;
        pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        wreg[i]  <= '0;
        stage[i] <= '0;
      end
      dirty   <= '0;
      tag_err <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (host_load && dirty[i])
          wreg[i] <= stage[i];
        else if (word_end && widx == WIDX_W'(i) && tag_ok)
          wreg[i] <= word[COEF_W-1:0];
        if (word_end && widx == WIDX_W'(i))
          tag_err[i] <= ~tag_ok;
        if (host_we && host_idx == IDX_W'(i)) begin
          stage[i] <= host_data;
          dirty[i] <= 1'b1;
        end else if (host_load) begin
          dirty[i] <= 1'b0;
        end
      end
    end
  end

  assign cfg_q   = wreg[0];
  assign off_q   = wreg[1];
  assign offtc_q = wreg[2];
  assign fso_q   = wreg[3];
  assign fsotc_q = wreg[4];
endmodule

// File: rtl/shadow_loader_chk.sv
module shadow_loader_chk #(
  parameter int ADDR_W = 7,
  parameter int COEF_W = 12,
  parameter int NREG = 5,
  parameter int LAST_ADDR = 79
)(
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic host_load,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [COEF_W-1:0] cfg_q,
  input logic [COEF_W-1:0] off_q,
  input logic [COEF_W-1:0] offtc_q,
  input logic [COEF_W-1:0] fso_q,
  input logic [COEF_W-1:0] fsotc_q,
  input logic [NREG-1:0] tag_err
);
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> mem_addr == ADDR_W'($past(mem_addr) + 1'b1));

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_addr == '0);

  assert_end_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_addr) == ADDR_W'(LAST_ADDR));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) && !$past(host_load)) |->
      $stable({cfg_q, off_q, offtc_q, fso_q, fsotc_q}));

  assert_err_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(tag_err));
endmodule

bind shadow_loader shadow_loader_chk #(
  .ADDR_W(ADDR_W), .COEF_W(COEF_W), .NREG(NREG),
  .LAST_ADDR(NREG * (COEF_W + TAG_W) - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .host_load(host_load),
  .mem_addr(mem_addr), .cfg_q(cfg_q), .off_q(off_q), .offtc_q(offtc_q),
  .fso_q(fso_q), .fsotc_q(fsotc_q), .tag_err(tag_err)
);

// File: tb/shadow_loader_test.sv
module shadow_loader_test;
  localparam int REF = 300;
  logic clk = 0, rst_n = 0, sel = 1, u_flag = 0, wr_en = 0, session_open = 0;
  logic host_we = 0, host_load = 0;
  logic [2:0] host_idx = 0;
  logic [11:0] host_data = 0;
  logic [6:0] mem_addr;
  logic [127:0] mem;
  logic mem_bit;
  logic [11:0] cfg_q, off_q, offtc_q, fso_q, fsotc_q;
  logic busy;
  logic [4:0] tag_err;
  logic [11:0] exp_r [5];
  logic [4:0] exp_e;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;
  assign mem_bit = mem[mem_addr];

  shadow_loader #(.REFRESH_CYCLES(REF)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .u_flag(u_flag), .wr_en(wr_en),
    .session_open(session_open), .host_we(host_we), .host_idx(host_idx),
    .host_data(host_data), .host_load(host_load), .mem_addr(mem_addr),
    .mem_bit(mem_bit), .cfg_q(cfg_q), .off_q(off_q), .offtc_q(offtc_q),
    .fso_q(fso_q), .fsotc_q(fsotc_q), .busy(busy), .tag_err(tag_err));

  function automatic logic [15:0] mkword(int w, logic [11:0] d, bit good);
    logic [3:0] t = 4'(8 + w);
    return {good ? t : ~t, d};
  endfunction

  task automatic put(int w, logic [11:0] d, bit good);
    mem[16*w +: 16] = mkword(w, d, good);
  endtask

  task automatic model_reload();
    for (int w = 0; w < 5; w++) begin
      if (mem[16*w+12 +: 4] == 4'(8 + w)) begin
        exp_r[w] = mem[16*w +: 12];
        exp_e[w] = 1'b0;
      end else exp_e[w] = 1'b1;
    end
  endtask

  task automatic check(string tag, int got, int expv);
    tests++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic check_regs(string tag);
    check({tag, " cfg"}, cfg_q, exp_r[0]);
    check({tag, " off"}, off_q, exp_r[1]);
    check({tag, " offtc"}, offtc_q, exp_r[2]);
    check({tag, " fso"}, fso_q, exp_r[3]);
    check({tag, " fsotc"}, fsotc_q, exp_r[4]);
    check({tag, " tag_err"}, tag_err, exp_e);
  endtask

  task automatic wait_load(string tag);
    int t = 0;
    while (!busy && t < 600) begin @(negedge clk); t++; end
    while (busy && t < 2000) begin @(negedge clk); t++; end
    check({tag, " reload finished"}, int'(t < 2000 && t > 0), 1);
  endtask

  task automatic pulse_sel();
    @(negedge clk) sel = 0;
    @(negedge clk) sel = 1;
  endtask

  task automatic quiet(int n, string tag);
    int seen = 0;
    repeat (n) begin @(negedge clk); if (busy) seen++; end
    check({tag, " no reload"}, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int w = 0; w < 8; w++) put(w, 12'h0, 1'b1);
    for (int w = 0; w < 5; w++) put(w, 12'h111 * (w + 1), 1'b1);
    mem[80 +: 48] = '0;
    for (int w = 0; w < 5; w++) exp_r[w] = '0;
    exp_e = '0;
    repeat (3) @(negedge clk);
    check("R1 reset cfg", cfg_q, 0);
    check("R1 reset fsotc", fsotc_q, 0);
    check("R1 reset tag_err", tag_err, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 1);
    check("R1 off zero during load", off_q, 0);
    n = 0;
    while (busy && n < 500) begin n++; @(negedge clk); end
    check("R2 busy length", n, 80);
    model_reload();
    check_regs("R2 power-up load order");

    put(2, 12'hABC, 1'b0); put(0, 12'h5A5, 1'b1);
    pulse_sel(); wait_load("R4 sel reload");
    model_reload();
    check_regs("R3 bad tag word 2");
    check("R3 flag bit 2", tag_err[2], 1);

    put(2, 12'h321, 1'b1);
    pulse_sel(); wait_load("R3 recover");
    model_reload();
    check_regs("R3 flag cleared");

    u_flag = 1;
    put(1, 12'hFFF, 1'b1);
    pulse_sel();
    quiet(150, "R4 u_flag=1");
    check_regs("R4 hold with u_flag");
    u_flag = 0;

    pulse_sel();
    repeat (10) @(negedge clk);
    pulse_sel();
    n = 0;
    for (int t = 0; t < 400; t++) begin @(negedge clk); if (busy) n++; end
    check("R7 queued second reload", n, 68 + 80);
    model_reload();
    check_regs("R7 after queue");

    put(3, 12'h0F0, 1'b1);
    wr_en = 1;
    repeat (REF + 120) @(negedge clk);
    model_reload();
    wr_en = 0;
    while (busy) @(negedge clk);
    check_regs("R5 periodic refresh");
    put(4, 12'h777, 1'b1);
    quiet(3 * REF, "R5 wr_en low");
    check_regs("R5 no refresh wr_en low");
    wr_en = 1; session_open = 1;
    quiet(3 * REF, "R5 session open");
    check_regs("R5 no refresh in session");
    wr_en = 0; session_open = 0;

    @(negedge clk) begin host_we = 1; host_idx = 1; host_data = 12'h9E1; end
    @(negedge clk) host_we = 0;
    repeat (4) @(negedge clk);
    check_regs("R6 staged not applied");
    @(negedge clk) begin host_we = 1; host_idx = 3; host_data = 12'h4C3; end
    @(negedge clk) begin host_idx = 6; host_data = 12'hDDD; end
    @(negedge clk) begin host_we = 0; host_load = 1; end
    @(negedge clk) host_load = 0;
    exp_r[1] = 12'h9E1; exp_r[3] = 12'h4C3;
    check_regs("R6 load strobe applies two");

    for (int it = 0; it < 15; it++) begin
      for (int w = 0; w < 5; w++)
        put(w, 12'($urandom), ($urandom % 4) != 0);
      pulse_sel(); wait_load("R2 random");
      model_reload();
      check_regs($sformatf("R3 random %0d", it));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule